// File: doc/BRIEF.md
# BCD Time-of-Day Clock Chain

This block keeps wall-clock time in packed BCD. A single-cycle enable that pulses at the reference crystal rate (32.768 kHz by default) feeds a binary prescaler. Every 2^PRESCALE_BITS enables the prescaler produces a one-second tick. The tick steps a chain of decimal digit counters: a units digit that counts to nine and a tens digit that counts to five form each of the seconds and minutes fields, and a two-digit hours counter sits above them. Everything runs on one clock. Each stage passes its rollover upward as a one-cycle enable; no stage clocks the next.

The hours are always counted internally as 00 to 23. A mode input chooses how they are shown. In 24-hour mode the output is the raw count. In 12-hour mode it is shown as 01 to 12, with a separate afternoon flag, and the half-day carry fires at both noon and midnight. Because the mode only changes the display and the carry, switching mode never changes the stored time.

A synchronous load port sets the time and restarts the prescaler. In 12-hour mode the loaded hour is read together with the loaded afternoon flag. Any loaded field that is not a legal value is replaced by zero.

Top module: `tod_bcd_clock`

## Requirements
- R1: `tick_1hz` is high only in a cycle with `ref_en` high, and it is high on exactly every 2^PRESCALE_BITS-th `ref_en` pulse counted from reset or the last load.
- R2: `sec_bcd` holds tens in bits [7:4] and units in bits [3:0]. The units digit steps 0 to 9 and then returns to 0. The seconds field goes from 59 to 00, and `sec_wrap` is high in the tick cycle that performs this 59 to 00 step.
- R3: `min_bcd` uses the same layout and range. It changes only in a cycle where `sec_wrap` is high, or on a load. `min_wrap` is high exactly when `sec_wrap` is high and the minutes read 59.
- R4: The tens digit of seconds or minutes advances only in a cycle where its units digit reads 9 and the enable feeding that units digit is high. Otherwise it holds, including while `ref_en` is low.
- R5: With `mode_12h` low, `hr_bcd` runs 00 to 23 in BCD. The time 23:59:59 steps to 00:00:00, and `day_wrap` is high in that tick cycle only.
- R6: With `mode_12h` high, `hr_bcd` runs 12, 01, … 11 and then 12 again. `pm` is high for internal hours 12 to 23. `day_wrap` is high in the tick cycles that leave 11:59:59, in both the morning and the evening half.
- R7: When `load` is high, the three fields take the load values at the next clock edge and the prescaler restarts from zero. `tick_1hz` is low in any cycle where `load` is high.
- R8: A loaded field that is not legal is stored as zero. For seconds and minutes, a field is illegal if either nibble is above 9 or the value is above 59. For hours in 24-hour mode, the limit is 23. In 12-hour mode, any hour outside 01 to 12 is illegal, and zero then shows as 12 with `pm` low.
- R9: After reset the time is 00:00:00, `pm` is low, the prescaler is cleared, and no tick or carry is high.
- R10: Changing `mode_12h` changes only how the hours are shown. Seconds, minutes and the internal hour hold, so the 24-hour hour h shows in 12-hour mode as ((h mod 12), or 12 if that is 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle pulse at the reference crystal rate |
| mode_12h | input | 1 | 1 selects 12-hour display and half-day carry, 0 selects 24-hour |
| load | input | 1 | Synchronous time load strobe |
| load_hr | input | 8 | BCD hour to load (12-hour or 24-hour form, per mode) |
| load_min | input | 8 | BCD minutes to load |
| load_sec | input | 8 | BCD seconds to load |
| load_pm | input | 1 | Afternoon flag used with `load_hr` in 12-hour mode |
| hr_bcd | output | 8 | Displayed hour, tens in [7:4], units in [3:0] |
| min_bcd | output | 8 | Minutes, tens in [7:4], units in [3:0] |
| sec_bcd | output | 8 | Seconds, tens in [7:4], units in [3:0] |
| pm | output | 1 | High for internal hours 12 to 23 |
| tick_1hz | output | 1 | One-second enable out of the prescaler |
| sec_wrap | output | 1 | Seconds 59 to 00 carry |
| min_wrap | output | 1 | Minutes 59 to 00 carry |
| day_wrap | output | 1 | Day carry (24-hour) or half-day carry (12-hour) |

## Verification
The bench runs a small prescaler and walks a full hour second by second, so every units-to-tens carry and the minute carry are checked against times computed arithmetically from a seconds-of-day count. A counter that stepped its tens digit on any tick, or that let a digit reach 1010, would show a wrong field within ten seconds. Loads just before every hour boundary in both modes check the hour transitions. A 24-hour counter that forgot 23 wraps to 00 would read 24. A 12-hour display that wrapped at 12 rather than after 11 would show 00 or flip `pm` in the wrong place. Further loads cover the remaining cases: illegal values must clear to zero, a load must restart a half-counted prescaler (a stale one ticks too early), and a mode change midway through the day must leave the time unchanged.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef logic [7:0] bcd2_t;

  // Packed two-digit BCD to binary (0..99).
  function automatic logic [6:0] bcd_to_bin(input bcd2_t b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  // Binary (0..99) to packed two-digit BCD.
  function automatic bcd2_t bin_to_bcd(input logic [6:0] v);
    return bcd2_t'(8'(v / 7'd10) << 4) | bcd2_t'(8'(v % 7'd10));
  endfunction

  function automatic logic nibbles_ok(input bcd2_t b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  // Legal field with an inclusive binary upper bound.
  function automatic logic field_ok(input bcd2_t b, input logic [6:0] max_bin);
    return nibbles_ok(b) && (bcd_to_bin(b) <= max_bin);
  endfunction

  function automatic logic hr12_ok(input bcd2_t b);
    return nibbles_ok(b) && (bcd_to_bin(b) >= 7'd1) && (bcd_to_bin(b) <= 7'd12);
  endfunction

  // 12-hour hour plus afternoon flag to the internal 24-hour count.
  function automatic bcd2_t hr12_to_24(input bcd2_t b, input logic aft);
    logic [6:0] h;
    h = bcd_to_bin(b);
    if (h == 7'd12) h = 7'd0;
    if (aft) h = h + 7'd12;
    return bin_to_bcd(h);
  endfunction

  // Internal 24-hour count to the 12-hour display value.
  function automatic bcd2_t hr24_to_12(input bcd2_t b);
    logic [6:0] h;
    h = bcd_to_bin(b);
    if (h >= 7'd12) h = h - 7'd12;
    if (h == 7'd0) h = 7'd12;
    return bin_to_bcd(h);
  endfunction

  function automatic logic hr_is_pm(input bcd2_t b);
    return bcd_to_bin(b) >= 7'd12;
  endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int unsigned BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);

  localparam logic [BITS-1:0] TERMINAL = {BITS{1'b1}};

  logic [BITS-1:0] cnt_q;
  logic [BITS-1:0] cnt_d;

  assign tick = en && !clr && (cnt_q == TERMINAL);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tod_bcd_digit.sv
module tod_bcd_digit #(
  parameter logic [3:0] MAX = 4'd9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       ld,
  input  logic [3:0] ld_val,
  output logic [3:0] q,
  output logic       wrap
);

  logic [3:0] q_d;

  assign wrap = adv && !ld && (q == MAX);

  always_comb begin
    q_d = q;
    if (ld)                q_d = ld_val;
    else if (adv && q == MAX) q_d = 4'd0;
    else if (adv)          q_d = q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 4'd0;
    else        q <= q_d;
  end

endmodule

// File: rtl/tod_hour_ctr.sv
module tod_hour_ctr
  import tod_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  ld,
  input  bcd2_t ld_val,
  output bcd2_t q,
  output logic  wrap
);

  localparam bcd2_t LAST_HOUR = 8'h23;

  logic [3:0] tens_q, units_q;
  logic [3:0] tens_d, units_d;

  assign q    = {tens_q, units_q};
  assign wrap = adv && !ld && (q == LAST_HOUR);

  always_comb begin
    tens_d  = tens_q;
    units_d = units_q;
    if (ld) begin
      tens_d  = ld_val[7:4];
      units_d = ld_val[3:0];
    end else if (adv) begin
      if (q == LAST_HOUR) begin
        tens_d  = 4'd0;
        units_d = 4'd0;
      end else if (units_q == 4'd9) begin
        tens_d  = tens_q + 4'd1;
        units_d = 4'd0;
      end else begin
        units_d = units_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens_q  <= 4'd0;
      units_q <= 4'd0;
    end else begin
      tens_q  <= tens_d;
      units_q <= units_d;
    end
  end

endmodule

// File: rtl/tod_bcd_clock.sv
module tod_bcd_clock
  import tod_pkg::*;
#(
  parameter int unsigned PRESCALE_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       mode_12h,
  input  logic       load,
  input  logic [7:0] load_hr,
  input  logic [7:0] load_min,
  input  logic [7:0] load_sec,
  input  logic       load_pm,
  output logic [7:0] hr_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] sec_bcd,
  output logic       pm,
  output logic       tick_1hz,
  output logic       sec_wrap,
  output logic       min_wrap,
  output logic       day_wrap
);

  // Sub-hour digits: [0] sec units, [1] sec tens, [2] min units, [3] min tens.
  localparam int unsigned NDIG = 4;
  localparam logic [6:0] MAX_MS = 7'd59;
  localparam logic [6:0] MAX_H24 = 7'd23;

  logic               tick;
  logic [NDIG:0]      dig_adv;
  logic [NDIG-1:0]    dig_wrap;
  logic [NDIG*4-1:0]  dig_q;
  logic [NDIG*4-1:0]  dig_ld;
  bcd2_t              sec_ld, min_ld, hr_ld;
  bcd2_t              hr_int;
  logic               hr_wrap;
  logic               half_day_edge;

  // Load clamping: any illegal field becomes zero.
  always_comb begin
    sec_ld = field_ok(load_sec, MAX_MS) ? load_sec : 8'h00;
    min_ld = field_ok(load_min, MAX_MS) ? load_min : 8'h00;
    if (mode_12h) hr_ld = hr12_ok(load_hr) ? hr12_to_24(load_hr, load_pm) : 8'h00;
    else          hr_ld = field_ok(load_hr, MAX_H24) ? load_hr : 8'h00;
  end

  assign dig_ld = {min_ld, sec_ld};

  tod_prescaler #(.BITS(PRESCALE_BITS)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ref_en),
    .clr  (load),
    .tick (tick)
  );

  assign dig_adv[0] = tick;

  genvar gi;
  generate
    for (gi = 0; gi < NDIG; gi++) begin : g_dig
      localparam logic [3:0] DMAX = (gi % 2 == 0) ? 4'd9 : 4'd5;
      tod_bcd_digit #(.MAX(DMAX)) u_digit (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (dig_adv[gi]),
        .ld    (load),
        .ld_val(dig_ld[gi*4 +: 4]),
        .q     (dig_q[gi*4 +: 4]),
        .wrap  (dig_wrap[gi])
      );
      assign dig_adv[gi+1] = dig_wrap[gi];
    end
  endgenerate

  tod_hour_ctr u_hour (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (dig_adv[NDIG]),
    .ld    (load),
    .ld_val(hr_ld),
    .q     (hr_int),
    .wrap  (hr_wrap)
  );

  assign half_day_edge = dig_adv[NDIG] && ((hr_int == 8'h11) || (hr_int == 8'h23));

  assign sec_bcd  = dig_q[7:0];
  assign min_bcd  = dig_q[15:8];
  assign hr_bcd   = mode_12h ? hr24_to_12(hr_int) : hr_int;
  assign pm       = hr_is_pm(hr_int);
  assign tick_1hz = tick;
  assign sec_wrap = dig_wrap[1];
  assign min_wrap = dig_wrap[3];
  assign day_wrap = mode_12h ? half_day_edge : hr_wrap;

endmodule

// File: rtl/tod_bcd_clock_chk.sv
module tod_bcd_clock_chk #(
  parameter int unsigned PRESCALE_BITS = 15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_en,
  input logic       mode_12h,
  input logic       load,
  input logic [7:0] hr_bcd,
  input logic [7:0] min_bcd,
  input logic [7:0] sec_bcd,
  input logic       pm,
  input logic       tick_1hz,
  input logic       sec_wrap,
  input logic       min_wrap,
  input logic       day_wrap
);

  localparam logic [PRESCALE_BITS:0] EN_LAST = {1'b0, {PRESCALE_BITS{1'b1}}};

  // Enables seen since reset, last load or last tick.
  logic [PRESCALE_BITS:0] en_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_cnt <= '0;
    else if (load || tick_1hz) en_cnt <= '0;
    else if (ref_en)           en_cnt <= en_cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> (ref_en && en_cnt == EN_LAST)); // R1
  AST_NO_MISSED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    en_cnt <= EN_LAST); // R1
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_bcd[3:0] <= 4'd9 && sec_bcd[7:4] <= 4'd5)); // R2
  AST_SEC_WRAP_AT_59: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |-> (tick_1hz && sec_bcd == 8'h59)); // R2
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !sec_wrap) |=> $stable(min_bcd)); // R3
  AST_MIN_WRAP_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    min_wrap |-> (sec_wrap && min_bcd == 8'h59)); // R3
  AST_SEC_TENS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick_1hz && sec_bcd[3:0] == 4'd9)) |=> $stable(sec_bcd[7:4])); // R4
  AST_HR24_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_12h |-> (hr_bcd <= 8'h23 && hr_bcd[3:0] <= 4'd9)); // R5
  AST_DAY_WRAP_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    day_wrap |-> min_wrap); // R5
  AST_HR12_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_12h |-> (hr_bcd != 8'h00 && hr_bcd <= 8'h12 && hr_bcd[3:0] <= 4'd9)); // R6
  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_12h && $past(mode_12h) && !$past(load) && pm != $past(pm)) |-> $past(day_wrap)); // R6
  AST_LOAD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !tick_1hz); // R7

endmodule

bind tod_bcd_clock tod_bcd_clock_chk #(.PRESCALE_BITS(PRESCALE_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_en  (ref_en),
  .mode_12h(mode_12h),
  .load    (load),
  .hr_bcd  (hr_bcd),
  .min_bcd (min_bcd),
  .sec_bcd (sec_bcd),
  .pm      (pm),
  .tick_1hz(tick_1hz),
  .sec_wrap(sec_wrap),
  .min_wrap(min_wrap),
  .day_wrap(day_wrap)
);

// File: tb/test_tod_bcd_clock.sv
module test_tod_bcd_clock;

  localparam int unsigned PB  = 2;
  localparam int          DIV = 1 << PB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       mode_12h = 1'b0;
  logic       load = 1'b0;
  logic [7:0] load_hr = 8'h00;
  logic [7:0] load_min = 8'h00;
  logic [7:0] load_sec = 8'h00;
  logic       load_pm = 1'b0;
  logic [7:0] hr_bcd, min_bcd, sec_bcd;
  logic       pm, tick_1hz, sec_wrap, min_wrap, day_wrap;

  int n_chk = 0;
  int n_fail = 0;
  int t = 0;  // expected seconds of day

  always #2 clk = ~clk;

  tod_bcd_clock #(.PRESCALE_BITS(PB)) i_tod_bcd_clock (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .mode_12h(mode_12h),
    .load(load), .load_hr(load_hr), .load_min(load_min), .load_sec(load_sec),
    .load_pm(load_pm), .hr_bcd(hr_bcd), .min_bcd(min_bcd), .sec_bcd(sec_bcd),
    .pm(pm), .tick_1hz(tick_1hz), .sec_wrap(sec_wrap), .min_wrap(min_wrap),
    .day_wrap(day_wrap)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int disp12(input int h24);
    return (h24 % 12 == 0) ? 12 : (h24 % 12);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic check_time();
    int h;
    h = t / 3600;
    check("R2 sec units", 32'(sec_bcd[3:0]), 32'((t % 60) % 10));
    check("R4 sec tens", 32'(sec_bcd[7:4]), 32'((t % 60) / 10));
    check("R3 minutes", 32'(min_bcd), 32'(to_bcd((t / 60) % 60)));
    if (mode_12h) check("R6 hours 12h", 32'(hr_bcd), 32'(to_bcd(disp12(h))));
    else          check("R5 hours 24h", 32'(hr_bcd), 32'(to_bcd(h)));
    check("R6 pm flag", 32'(pm), 32'(h >= 12));
  endtask

  // One second of reference enables; optional idle cycles between them.
  task automatic advance_second(input bit gap);
    for (int k = 0; k < DIV; k++) begin
      @(negedge clk);
      ref_en = 1'b1;
      #1;
      check("R1 tick position", 32'(tick_1hz), 32'(k == DIV - 1));
      if (k == DIV - 1) begin
        check("R2 sec_wrap", 32'(sec_wrap), 32'(t % 60 == 59));
        check("R3 min_wrap", 32'(min_wrap), 32'(t % 3600 == 3599));
        if (mode_12h) check("R6 half-day wrap", 32'(day_wrap), 32'(t % 43200 == 43199));
        else          check("R5 day wrap", 32'(day_wrap), 32'(t == 86399));
        t = (t + 1) % 86400;
      end
      if (gap || k == DIV - 1) begin
        @(negedge clk);
        ref_en = 1'b0;
        #1;
        check_time();
      end
    end
  endtask

  task automatic load_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                           input logic p, input bit with_en, input int exp_t);
    @(negedge clk);
    load = 1'b1; load_hr = h; load_min = m; load_sec = s; load_pm = p;
    ref_en = with_en;
    #1;
    check("R7 no tick during load", 32'(tick_1hz), 32'd0);
    @(negedge clk);
    load = 1'b0; ref_en = 1'b0;
    t = exp_t;
    #1;
    check_time();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check("R9 reset sec", 32'(sec_bcd), 32'h00);
    check("R9 reset min", 32'(min_bcd), 32'h00);
    check("R9 reset hr", 32'(hr_bcd), 32'h00);
    check("R9 reset pm", 32'(pm), 32'd0);
    check("R9 reset carries", 32'({tick_1hz, sec_wrap, min_wrap, day_wrap}), 32'd0);

    // R1 R4: sparse enables, outputs must hold in idle cycles
    for (int i = 0; i < 12; i++) advance_second(1'b1);
    // R2 R3 R4: walk past an hour boundary second by second
    for (int i = 0; i < 3700; i++) advance_second(1'b0);

    // R5: every hour boundary in 24-hour mode
    for (int h = 0; h < 24; h++) begin
      load_time(to_bcd(h), 8'h59, 8'h58, 1'b0, 1'b0, h * 3600 + 3598);
      advance_second(1'b0);
      advance_second(1'b0);
    end

    // R10: mode change keeps time
    load_time(8'h15, 8'h30, 8'h07, 1'b0, 1'b0, 15 * 3600 + 30 * 60 + 7);
    @(negedge clk); mode_12h = 1'b1; #1;
    check("R10 hr after switch to 12h", 32'(hr_bcd), 32'h03);
    check_time();
    @(negedge clk); mode_12h = 1'b0; #1;
    check("R10 hr after switch back", 32'(hr_bcd), 32'h15);
    check_time();

    // R6: every hour boundary in 12-hour mode
    mode_12h = 1'b1;
    for (int h = 0; h < 24; h++) begin
      load_time(to_bcd(disp12(h)), 8'h59, 8'h58, (h >= 12), 1'b0, h * 3600 + 3598);
      advance_second(1'b0);
      advance_second(1'b0);
    end

    // R7: load restarts a half-counted prescaler
    mode_12h = 1'b0;
    load_time(8'h10, 8'h20, 8'h30, 1'b0, 1'b0, 10 * 3600 + 20 * 60 + 30);
    for (int i = 0; i < DIV - 1; i++) begin
      @(negedge clk); ref_en = 1'b1; #1;
      check("R1 no early tick", 32'(tick_1hz), 32'd0);
    end
    load_time(8'h10, 8'h20, 8'h30, 1'b0, 1'b1, 10 * 3600 + 20 * 60 + 30);
    advance_second(1'b0);

    // R8: illegal loads clamp to zero
    load_time(8'h24, 8'h4A, 8'h60, 1'b0, 1'b0, 0);
    check("R8 clamp 24h", 32'({hr_bcd, min_bcd, sec_bcd}), 32'h000000);
    load_time(8'h07, 8'h60, 8'h5F, 1'b0, 1'b0, 7 * 3600);
    mode_12h = 1'b1;
    load_time(8'h13, 8'h12, 8'h59, 1'b1, 1'b0, 12 * 60 + 59);
    check("R8 clamp 12h hour shows 12", 32'(hr_bcd), 32'h12);
    check("R8 clamp 12h pm low", 32'(pm), 32'd0);
    load_time(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 0);
    check("R8 zero hour in 12h", 32'({hr_bcd, pm}), 32'({8'h12, 1'b0}));
    advance_second(1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule